// File: doc/BRIEF.md
# Lockable Standby-Aware Watchdog Timer

This block is a small watchdog. It counts rising edges of one tick input, chosen from a bank of prescaler taps. When its counter overflows it raises a reset request for one clock cycle. Software turns it on by writing a 4-bit activation key into a control field. A strap input can instead force it on from reset. In that case the tick tap is fixed and the software selection is ignored. Once the watchdog is running, no register write can turn it off. Only a system reset does that.

The tick-source selection is taken only in the write that activates the timer. It is frozen from then on. Taps that come from the main clock stop while the main oscillator is halted, in stop or watch mode. Slow taps keep ticking in those modes. Software keeps the timer quiet by rewriting the key. Clearing the prescaler behind the chosen tap also clears the watchdog. Entering any standby mode clears the count, except when a strapped-on timer has been told to keep running through standby.

Top module: `standby_watchdog`

## Requirements
- R1: After the synchronous reset, `rst_req` is low and the counter is zero. With `hw_en` low and no key write, the block stays inactive and never requests a reset, however many ticks arrive.
- R2: A write with `wr_ctl` equal to 4'b0101 activates an inactive timer and captures `wr_sel` as the tick source. Writes to `wr_ctl` with any value never deactivate the timer afterwards.
- R3: Once the timer is active, later writes cannot change the tick source. A key write that carries a different `wr_sel` leaves the original tap in use.
- R4: Writing 4'b0101 to a running timer restarts its count from zero. Any other `wr_ctl` value has no effect on the count.
- R5: The counter is 2 bits wide and advances once per rising edge of the selected tap, where an edge is the tap high while it was low in the previous clock. On the fourth counted edge, `rst_req` is high in the cycle after the edge is sampled, for exactly one cycle. The count then starts again from zero.
- R6: Select codes with bit 0 set, and the codes 3'b100 and 3'b110, choose slow taps. The codes 3'b000 and 3'b010 choose main-clock taps. While `stop_i` or `watch_i` is high, edges on a main-clock tap are not counted. Slow taps count in every mode, and main-clock taps still count during `sleep_i`.
- R7: With `hw_en` strapped high, the timer is active from the first cycle after reset without any write. Its tick source is tap `HW_SEL`, 3'b111 by default, and `wr_sel` has no effect.
- R8: A high `src_clr` clears the counter.
- R9: A rising edge of the OR of `sleep_i`, `stop_i` and `watch_i` clears the counter. The exception is when both `hw_en` and `hw_keep` are high: the count is then kept and continues through standby.
- R10: When a clear (`src_clr` or a restart key write) falls in the same cycle as a counted edge, the clear wins and the edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_en | input | 1 | Strap: watchdog forced on with the fixed tap |
| hw_keep | input | 1 | Strap: strapped-on timer keeps counting through standby |
| wr_en | input | 1 | Register write strobe |
| wr_ctl | input | 4 | Control field write data (activation key) |
| wr_sel | input | 3 | Tick-source select write data |
| taps | input | 8 | Prescaler tap levels, one per select code |
| sleep_i | input | 1 | Sleep mode indication |
| stop_i | input | 1 | Stop mode indication (main clock halted) |
| watch_i | input | 1 | Watch mode indication (main clock halted) |
| src_clr | input | 1 | The counter behind the selected tap is being cleared |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The overflow path is driven with runs of tap edges of different lengths: three edges, which must stay silent, and a fourth, which must fire. These runs are split by key rewrites, non-key writes, source clears and standby entries. Whether the pulse moves or holds shows if each event cleared the count or left it alone. Edges on taps other than the selected one, on main-clock taps during stop, and on slow taps during watch or stop separate the source lock from the oscillator gating. Clears placed in the same cycle as an edge show that the clear takes priority. Repeating the standby runs with the strap set, with and without the keep option, contrasts the cleared count with the retained one.

// File: rtl/standby_watchdog.sv
module standby_watchdog #(
  parameter int              SEL_W  = 3,
  parameter int              CNT_W  = 2,
  parameter logic [3:0]      KEY    = 4'b0101,
  parameter logic [SEL_W-1:0] HW_SEL = '1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    hw_en,
  input  logic                    hw_keep,
  input  logic                    wr_en,
  input  logic [3:0]              wr_ctl,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [(1<<SEL_W)-1:0]   taps,
  input  logic                    sleep_i,
  input  logic                    stop_i,
  input  logic                    watch_i,
  input  logic                    src_clr,
  output logic                    rst_req
);
  localparam int               NTAP    = 1 << SEL_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sw_on, stby_q;
  logic [SEL_W-1:0] sel_q, src;
  logic [NTAP-1:0]  taps_q;
  logic [CNT_W-1:0] cnt;
  logic active, key_wr, slow_src, main_halted, in_stby, stby_entry, tick, restart;

  assign active      = sw_on | hw_en;
  assign key_wr      = wr_en && (wr_ctl == KEY);
  assign src         = hw_en ? HW_SEL : sel_q;
  assign slow_src    = src[0] | src[SEL_W-1];
  assign main_halted = stop_i | watch_i;
  assign in_stby     = sleep_i | stop_i | watch_i;
  assign stby_entry  = in_stby & ~stby_q;
  assign tick        = taps[src] & ~taps_q[src] & (slow_src | ~main_halted);
  assign restart     = (key_wr & active) | src_clr | (stby_entry & ~(hw_en & hw_keep));

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_on   <= 1'b0;
      sel_q   <= '0;
      taps_q  <= '0;
      stby_q  <= 1'b0;
      cnt     <= '0;
      rst_req <= 1'b0;
    end else begin
      taps_q  <= taps;
      stby_q  <= in_stby;
      rst_req <= 1'b0;
      if (key_wr && !active) begin
        sw_on <= 1'b1;
        sel_q <= wr_sel;
      end
      if (!active || restart) begin
        cnt <= '0;
      end else if (tick) begin
        cnt     <= cnt + 1'b1;
        rst_req <= (cnt == CNT_MAX);
      end
    end
  end

  a_r2_stays_on: assert property (@(posedge clk) disable iff (rst)
    sw_on |=> sw_on);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |=> (cnt == '0 && !rst_req));
  a_r3_sel_locked: assert property (@(posedge clk) disable iff (rst)
    sw_on |=> $stable(sel_q));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  a_r5_wraps_to_zero: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> cnt == '0);
  a_r8_src_clear: assert property (@(posedge clk) disable iff (rst)
    src_clr |=> (cnt == '0 && !rst_req));
  a_r9_standby_clear: assert property (@(posedge clk) disable iff (rst)
    (stby_entry && !(hw_en && hw_keep)) |=> cnt == '0);
  a_r6_main_halted: assert property (@(posedge clk) disable iff (rst)
    (main_halted && !slow_src) |=> (cnt == $past(cnt) || cnt == '0) && !rst_req);
endmodule

// File: tb/tb_standby_watchdog.sv
module tb_standby_watchdog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_en = 1'b0, hw_keep = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_ctl = '0;
  logic [2:0] wr_sel = '0;
  logic [7:0] taps = '0;
  logic       sleep_i = 1'b0, stop_i = 1'b0, watch_i = 1'b0, src_clr = 1'b0;
  logic       rst_req;

  localparam logic [3:0] KEY = 4'b0101;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int    qc[$];
  bit    qv[$];
  string qt[$];

  standby_watchdog dut (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_keep(hw_keep), .wr_en(wr_en),
    .wr_ctl(wr_ctl), .wr_sel(wr_sel), .taps(taps), .sleep_i(sleep_i),
    .stop_i(stop_i), .watch_i(watch_i), .src_clr(src_clr), .rst_req(rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(bit v, string t);
    qc.push_back(cyc + 1);
    qv.push_back(v);
    qt.push_back(t);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(string t);
    push(1'b0, t);
    step();
  endtask

  task automatic do_reset(bit hw, bit keep);
    rst = 1'b1; hw_en = hw; hw_keep = keep; wr_en = 1'b0; taps = '0;
    sleep_i = 1'b0; stop_i = 1'b0; watch_i = 1'b0; src_clr = 1'b0;
    idle("R1 in reset");
    idle("R1 in reset");
    rst = 1'b0;
    idle("R1 after reset");
  endtask

  task automatic wr(logic [3:0] ctl, logic [2:0] sel, string t);
    wr_en = 1'b1; wr_ctl = ctl; wr_sel = sel;
    push(1'b0, t);
    step();
    wr_en = 1'b0;
  endtask

  task automatic tick_with(int idx, bit exp, bit clr, bit kw, string t);
    taps[idx] = 1'b1;
    src_clr = clr;
    if (kw) begin
      wr_en = 1'b1; wr_ctl = KEY; wr_sel = 3'd0;
    end
    push(exp, t);
    step();
    taps[idx] = 1'b0; src_clr = 1'b0; wr_en = 1'b0;
    push(1'b0, t);
    step();
  endtask

  task automatic ticks(int idx, int n, bit exp_last, string t);
    for (int i = 0; i < n; i++)
      tick_with(idx, (i == n - 1) ? exp_last : 1'b0, 1'b0, 1'b0, t);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compare each queued expectation in its cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (qc.size() > 0 && qc[0] <= cyc) begin
        int c;
        bit v;
        string t;
        c = qc.pop_front();
        v = qv.pop_front();
        t = qt.pop_front();
        checks++;
        if (c != cyc) begin
          fails++;
          $display("FAIL %s: expectation for cycle %0d not sampled (now %0d), actual rst_req=%b expected %b",
                   t, c, cyc, rst_req, v);
        end else if (rst_req !== v) begin
          fails++;
          $display("FAIL %s: cycle %0d rst_req actual %b expected %b", t, cyc, rst_req, v);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    step();
    // R1: idle software timer ignores ticks
    do_reset(1'b0, 1'b0);
    ticks(0, 6, 1'b0, "R1 inactive no request");
    wr(4'b1010, 3'd0, "R1 non-key write keeps inactive");
    ticks(0, 5, 1'b0, "R1 inactive after non-key write");
    // R2, R5: activation and overflow
    wr(KEY, 3'd2, "R2 activation write");
    ticks(2, 3, 1'b0, "R5 three edges silent");
    ticks(2, 1, 1'b1, "R5 fourth edge overflows");
    ticks(2, 3, 1'b0, "R5 count restarts from zero");
    ticks(2, 1, 1'b1, "R5 second overflow");
    // R3: source locked
    wr(KEY, 3'd5, "R3 key write with new select");
    ticks(5, 4, 1'b0, "R3 other tap ignored");
    ticks(2, 3, 1'b0, "R3 original tap still used");
    ticks(2, 1, 1'b1, "R3 original tap overflows");
    // R4: non-key writes vs restart
    ticks(2, 2, 1'b0, "R4 partial count");
    wr(4'b0000, 3'd1, "R4 non-key write");
    wr(4'b1010, 3'd3, "R2 R4 non-key write does not stop");
    ticks(2, 1, 1'b0, "R4 count kept");
    ticks(2, 1, 1'b1, "R4 count kept overflows");
    ticks(2, 3, 1'b0, "R4 before restart");
    wr(KEY, 3'd2, "R4 restart write");
    ticks(2, 3, 1'b0, "R4 restart cleared count");
    ticks(2, 1, 1'b1, "R4 overflow after restart");
    // R8: source clear
    ticks(2, 3, 1'b0, "R8 before clear");
    src_clr = 1'b1; idle("R8 clear pulse"); src_clr = 1'b0;
    ticks(2, 3, 1'b0, "R8 clear reset count");
    ticks(2, 1, 1'b1, "R8 overflow after clear");
    // R10: clear beats tick
    ticks(2, 3, 1'b0, "R10 before clash");
    tick_with(2, 1'b0, 1'b1, 1'b0, "R10 src_clr with edge");
    ticks(2, 3, 1'b0, "R10 edge not counted");
    ticks(2, 1, 1'b1, "R10 overflow after clash");
    ticks(2, 3, 1'b0, "R10 before restart clash");
    tick_with(2, 1'b0, 1'b0, 1'b1, "R10 restart with edge");
    ticks(2, 3, 1'b0, "R10 restart edge not counted");
    ticks(2, 1, 1'b1, "R10 overflow after restart clash");
    // R9: software standby entry clears
    ticks(2, 3, 1'b0, "R9 before sleep");
    sleep_i = 1'b1; idle("R9 sleep entry"); sleep_i = 1'b0; idle("R9 sleep exit");
    ticks(2, 3, 1'b0, "R9 sleep cleared count");
    ticks(2, 1, 1'b1, "R9 overflow after sleep");

    // R6: main tap halted in stop, runs in sleep
    do_reset(1'b0, 1'b0);
    wr(KEY, 3'd2, "R6 select main tap");
    stop_i = 1'b1; idle("R6 stop entry");
    ticks(2, 4, 1'b0, "R6 main tap ignored in stop");
    stop_i = 1'b0; idle("R6 stop exit");
    ticks(2, 3, 1'b0, "R6 after stop");
    ticks(2, 1, 1'b1, "R6 overflow after stop");
    sleep_i = 1'b1; idle("R6 sleep entry");
    ticks(2, 3, 1'b0, "R6 main tap in sleep");
    ticks(2, 1, 1'b1, "R6 main tap overflows in sleep");
    sleep_i = 1'b0; idle("R6 sleep exit");
    do_reset(1'b0, 1'b0);
    wr(KEY, 3'd4, "R6 select slow code 100");
    watch_i = 1'b1; idle("R6 watch entry");
    ticks(4, 3, 1'b0, "R6 slow tap in watch");
    ticks(4, 1, 1'b1, "R6 slow tap overflows in watch");
    watch_i = 1'b0; idle("R6 watch exit");
    do_reset(1'b0, 1'b0);
    wr(KEY, 3'd3, "R6 select slow code 011");
    stop_i = 1'b1; idle("R6 stop entry slow");
    ticks(3, 3, 1'b0, "R6 slow tap in stop");
    ticks(3, 1, 1'b1, "R6 slow tap overflows in stop");
    stop_i = 1'b0; idle("R6 stop exit slow");

    // R7, R9: strapped on, keep running in standby
    do_reset(1'b1, 1'b1);
    ticks(7, 3, 1'b0, "R7 strapped active");
    ticks(7, 1, 1'b1, "R7 strapped overflow without write");
    wr(KEY, 3'd2, "R7 key write restarts");
    ticks(2, 4, 1'b0, "R7 select field ignored");
    ticks(7, 2, 1'b0, "R9 before stop keep");
    stop_i = 1'b1; idle("R9 stop entry keep");
    ticks(7, 1, 1'b0, "R9 count kept in stop");
    ticks(7, 1, 1'b1, "R9 overflow through stop");
    stop_i = 1'b0; idle("R9 stop exit keep");
    // R9: strapped on without keep
    do_reset(1'b1, 1'b0);
    ticks(7, 2, 1'b0, "R9 before sleep no keep");
    sleep_i = 1'b1; idle("R9 sleep entry no keep"); sleep_i = 1'b0; idle("R9 sleep exit no keep");
    ticks(7, 3, 1'b0, "R9 cleared without keep");
    ticks(7, 1, 1'b1, "R9 overflow without keep");

    idle("end");
    idle("end");
    step();
    summary();
    $finish;
  end
endmodule